// File: doc/BRIEF.md
# Multiplexed GPIO Pin Controller

This block controls a parameterizable bank of general-purpose pins, 32 by default. Each pin belongs either to the controller or to one of two on-chip peripherals, A or B. When the controller owns a pin, it drives the pad's output enable and output value from its own status bits. When a peripheral owns the pin, the selected peripheral supplies both of those signals. Pad input always passes straight through to the input lines of both peripherals. Each pin also has a pull-up control.

Software changes each of the five attributes through a pair of write strobes. One strobe sets bits and the other clears them, and a status word reads the result back. Ownership, peripheral choice, output enable, output data and pull-up state can each be written in any mode. This lets the level a pin will drive be preset before the controller takes the pin. Some pins have no peripheral behind them. Those pins are locked to controller ownership. The ownership each pin takes out of reset is a parameter.

Top module: `pinmux_ctrl`

## Requirements
- R1: After reset, ownership status equals `OWN_RESET | ~HAS_PERIPH`. The select, output-enable, data and pull-up status words all read 0. With the default parameters, ownership reads 0xFFFFFF00 and every pad has its pull-up on.
- R2: Attribute k uses three addresses: 3k to set, 3k+1 to clear and 3k+2 for status. The attributes are ownership (k=0, set means controller), peripheral select (k=1, set means B), output enable (k=2), output data (k=3) and pull-up disable (k=4, set means pull-up off). A 1 in `wr_data` sets or clears the matching bit, and a 0 leaves it unchanged.
- R3: For a pin whose `HAS_PERIPH` bit is 0, ownership writes have no effect, and its ownership bit always reads 1.
- R4: `pad_pullup_en` is the inverse of the pull-up status word. It responds to writes whatever the pin's owner.
- R5: On a controller-owned pin, `pad_oe` equals the output-enable status bit and `pad_out` equals the data status bit.
- R6: On a peripheral-owned pin, select 0 passes `pa_oe` and `pa_out` to the pad, and select 1 passes `pb_oe` and `pb_out`.
- R7: Select, output-enable and data writes take effect while a peripheral owns the pin. The preset values appear on the pad as soon as the controller takes the pin.
- R8: `pa_in` and `pb_in` both equal `pad_in` at all times, whatever the select or owner.
- R9: `rd_data` is registered. It loads the word at `rd_addr` on a cycle with `rd_en` high and holds otherwise. A status read in the same cycle as a write returns the old value, and a read one cycle later returns the new value. Set and clear addresses, and address 15, read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 4 | Write word address |
| wr_data | input | NUM_PINS | Write data, one bit per pin |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 4 | Read word address |
| rd_data | output | NUM_PINS | Registered read data |
| pad_in | input | NUM_PINS | Level sensed at each pad |
| pad_out | output | NUM_PINS | Level driven to each pad |
| pad_oe | output | NUM_PINS | Pad output enable |
| pad_pullup_en | output | NUM_PINS | Pull-up enable, 1 = on |
| pa_oe | input | NUM_PINS | Peripheral A output enable |
| pa_out | input | NUM_PINS | Peripheral A output value |
| pb_oe | input | NUM_PINS | Peripheral B output enable |
| pb_out | input | NUM_PINS | Peripheral B output value |
| pa_in | output | NUM_PINS | Pad input to peripheral A |
| pb_in | output | NUM_PINS | Pad input to peripheral B |

## Verification
The two functions that can fall in the same cycle are a status write and a status read. The read and write ports carry separate addresses, so both can be active on one edge. The bench provokes this by raising `wr_en` on the data-set address and `rd_en` on the data-status address in one cycle. It judges the result by requiring the pre-write word in that read and the post-write word in a read one cycle later. It also confirms that `rd_data` holds its value across idle cycles.

// File: rtl/pinmux_pkg.sv
// Package: shared constants for the pin controller.
// Assumes attribute k uses word addresses 3k (set), 3k+1 (clear), 3k+2 (status).
package pinmux_pkg;

    localparam int REG_ADDR_W = 4;
    localparam int NUM_ATTR   = 5;

    typedef enum int {
        ATTR_OWN = 0,   // 1 = controller owns pin
        ATTR_SEL = 1,   // 1 = peripheral B
        ATTR_OE  = 2,   // 1 = controller drives
        ATTR_DAT = 3,   // driven level
        ATTR_PU  = 4    // 1 = pull-up off
    } attr_e;

    function automatic logic [REG_ADDR_W-1:0] set_addr(int k);
        return REG_ADDR_W'(3 * k);
    endfunction

    function automatic logic [REG_ADDR_W-1:0] clr_addr(int k);
        return REG_ADDR_W'(3 * k + 1);
    endfunction

    function automatic logic [REG_ADDR_W-1:0] stat_addr(int k);
        return REG_ADDR_W'(3 * k + 2);
    endfunction

endpackage

// File: rtl/pinmux_setclr_reg.sv
// Module: one status word changed by set and clear strobes.
// Does: bits under WMASK follow set/clear; set wins over clear on the same bit.
// Assumes: bits outside WMASK stay at RST_VAL forever.
module pinmux_setclr_reg #(
    parameter int                 W       = 32,
    parameter logic [W-1:0]       RST_VAL = '0,
    parameter logic [W-1:0]       WMASK   = '1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] set_m;
    logic [W-1:0] clr_m;
    logic [W-1:0] stat_q;

    // Purpose: restrict strobes to the writable bits.
    always_comb begin
        set_m = set_i & WMASK;
        clr_m = clr_i & WMASK;
    end

    // Purpose: hold the status word; clear first, then set so set wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= RST_VAL;
        end else begin
            stat_q <= (stat_q & ~clr_m) | set_m;
        end
    end

    assign stat_o = stat_q;

    AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|set_m) |=> ((stat_o & $past(set_m)) == $past(set_m)));   // R2

    AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (|(clr_m & ~set_m)) |=> ((stat_o & $past(clr_m & ~set_m)) == '0));   // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (set_i == '0 && clr_i == '0) |=> $stable(stat_o));   // R2

endmodule

// File: rtl/pinmux_pad_mux.sv
// Module: per-pin output selection between controller, peripheral A and B.
// Does: controller-owned pins take local status; others take the selected peripheral.
// Assumes: all inputs are settled combinational levels in the same clock domain.
module pinmux_pad_mux #(
    parameter int N = 32
) (
    input  logic [N-1:0] own_i,
    input  logic [N-1:0] sel_i,
    input  logic [N-1:0] oe_i,
    input  logic [N-1:0] dat_i,
    input  logic [N-1:0] pa_oe_i,
    input  logic [N-1:0] pa_out_i,
    input  logic [N-1:0] pb_oe_i,
    input  logic [N-1:0] pb_out_i,
    output logic [N-1:0] pad_oe_o,
    output logic [N-1:0] pad_out_o
);

    for (genvar p = 0; p < N; p++) begin : g_pin
        logic per_oe;
        logic per_out;

        // Purpose: pick the peripheral named by the select bit.
        always_comb begin
            per_oe  = sel_i[p] ? pb_oe_i[p]  : pa_oe_i[p];
            per_out = sel_i[p] ? pb_out_i[p] : pa_out_i[p];
        end

        // Purpose: choose controller or peripheral drive for this pad.
        always_comb begin
            pad_oe_o[p]  = own_i[p] ? oe_i[p]  : per_oe;
            pad_out_o[p] = own_i[p] ? dat_i[p] : per_out;
        end
    end

endmodule

// File: rtl/pinmux_ctrl.sv
// Module: top of the multiplexed pin controller.
// Does: decodes the register bus into five set/clear status words, drives the
//       pads through the output mux and returns registered read data.
// Assumes: HAS_PERIPH bit 0 marks a pin with no peripheral; OWN_RESET gives the
//          reset ownership of pins that do have one.
module pinmux_ctrl
    import pinmux_pkg::*;
#(
    parameter int                  NUM_PINS   = 32,
    parameter logic [NUM_PINS-1:0] HAS_PERIPH = 32'h0FFF_FFFF,
    parameter logic [NUM_PINS-1:0] OWN_RESET  = 32'hFFFF_FF00
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [REG_ADDR_W-1:0] wr_addr,
    input  logic [NUM_PINS-1:0]   wr_data,
    input  logic                  rd_en,
    input  logic [REG_ADDR_W-1:0] rd_addr,
    output logic [NUM_PINS-1:0]   rd_data,
    input  logic [NUM_PINS-1:0]   pad_in,
    output logic [NUM_PINS-1:0]   pad_out,
    output logic [NUM_PINS-1:0]   pad_oe,
    output logic [NUM_PINS-1:0]   pad_pullup_en,
    input  logic [NUM_PINS-1:0]   pa_oe,
    input  logic [NUM_PINS-1:0]   pa_out,
    input  logic [NUM_PINS-1:0]   pb_oe,
    input  logic [NUM_PINS-1:0]   pb_out,
    output logic [NUM_PINS-1:0]   pa_in,
    output logic [NUM_PINS-1:0]   pb_in
);

    localparam logic [NUM_PINS-1:0] OWN_RST = OWN_RESET | ~HAS_PERIPH;

    logic [NUM_PINS-1:0] stat_a [NUM_ATTR];
    logic [NUM_PINS-1:0] rd_val;
    logic [NUM_PINS-1:0] rd_q;

    for (genvar k = 0; k < NUM_ATTR; k++) begin : g_attr
        localparam logic [NUM_PINS-1:0] RV = (k == ATTR_OWN) ? OWN_RST    : '0;
        localparam logic [NUM_PINS-1:0] WM = (k == ATTR_OWN) ? HAS_PERIPH : '1;
        logic [NUM_PINS-1:0] set_v;
        logic [NUM_PINS-1:0] clr_v;

        // Purpose: route write data to this attribute's set or clear strobe.
        always_comb begin
            set_v = (wr_en && wr_addr == set_addr(k)) ? wr_data : '0;
            clr_v = (wr_en && wr_addr == clr_addr(k)) ? wr_data : '0;
        end

        pinmux_setclr_reg #(
            .W       (NUM_PINS),
            .RST_VAL (RV),
            .WMASK   (WM)
        ) i_reg (
            .clk    (clk),
            .rst_n  (rst_n),
            .set_i  (set_v),
            .clr_i  (clr_v),
            .stat_o (stat_a[k])
        );
    end

    pinmux_pad_mux #(
        .N (NUM_PINS)
    ) i_pad_mux (
        .own_i     (stat_a[ATTR_OWN]),
        .sel_i     (stat_a[ATTR_SEL]),
        .oe_i      (stat_a[ATTR_OE]),
        .dat_i     (stat_a[ATTR_DAT]),
        .pa_oe_i   (pa_oe),
        .pa_out_i  (pa_out),
        .pb_oe_i   (pb_oe),
        .pb_out_i  (pb_out),
        .pad_oe_o  (pad_oe),
        .pad_out_o (pad_out)
    );

    // Purpose: pull-up is on where its disable bit is clear; inputs pass through.
    always_comb begin
        pad_pullup_en = ~stat_a[ATTR_PU];
        pa_in         = pad_in;
        pb_in         = pad_in;
    end

    // Purpose: select the status word named by the read address; others read 0.
    always_comb begin
        rd_val = '0;
        for (int k = 0; k < NUM_ATTR; k++) begin
            if (rd_addr == stat_addr(k)) begin
                rd_val = stat_a[k];
            end
        end
    end

    // Purpose: register read data on a read strobe, hold otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_q <= '0;
        end else if (rd_en) begin
            rd_q <= rd_val;
        end
    end

    assign rd_data = rd_q;

    AST_OWN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == clr_addr(ATTR_OWN))
        |=> ((stat_a[ATTR_OWN] & ~HAS_PERIPH) == ~HAS_PERIPH));   // R3

    AST_PULLUP_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == set_addr(ATTR_PU))
        |=> ((pad_pullup_en & $past(wr_data)) == '0));   // R4

    AST_OE_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == clr_addr(ATTR_OE))
        |=> ((pad_oe & $past(wr_data) & stat_a[ATTR_OWN]) == '0));   // R5

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));   // R9

endmodule

// File: tb/test_pinmux_ctrl.sv
// Bench: directed scenarios for pinmux_ctrl, one task each, with a bench-side model.
module test_pinmux_ctrl;

    localparam int          N    = 32;
    localparam logic [31:0] HASP = 32'h0FFF_FFFF;
    localparam logic [31:0] ORST = 32'hFFFF_FF00;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          wr_en, rd_en;
    logic [3:0]    wr_addr, rd_addr;
    logic [N-1:0]  wr_data, rd_data;
    logic [N-1:0]  pad_in, pad_out, pad_oe, pad_pullup_en;
    logic [N-1:0]  pa_oe, pa_out, pb_oe, pb_out, pa_in, pb_in;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    // bench model of the five status words
    logic [N-1:0] m_own, m_sel, m_oe, m_dat, m_pu;

    always #4 clk = ~clk;   // 125 MHz

    pinmux_ctrl #(.NUM_PINS(N), .HAS_PERIPH(HASP), .OWN_RESET(ORST)) i_pinmux_ctrl (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe),
        .pad_pullup_en(pad_pullup_en),
        .pa_oe(pa_oe), .pa_out(pa_out), .pb_oe(pb_oe), .pb_out(pb_out),
        .pa_in(pa_in), .pb_in(pb_in)
    );

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [3:0] a, input logic [N-1:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
        case (a)
            4'd0:  m_own = m_own | (d & HASP);
            4'd1:  m_own = m_own & ~(d & HASP);
            4'd3:  m_sel = m_sel | d;
            4'd4:  m_sel = m_sel & ~d;
            4'd6:  m_oe  = m_oe  | d;
            4'd7:  m_oe  = m_oe  & ~d;
            4'd9:  m_dat = m_dat | d;
            4'd10: m_dat = m_dat & ~d;
            4'd12: m_pu  = m_pu  | d;
            4'd13: m_pu  = m_pu  & ~d;
            default: ;
        endcase
    endtask

    task automatic bus_read(input logic [3:0] a, output logic [N-1:0] v);
        @(negedge clk);
        rd_en = 1'b1; rd_addr = a;
        @(posedge clk);
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    function automatic logic [N-1:0] exp_oe();
        return (m_own & m_oe) | (~m_own & ~m_sel & pa_oe) | (~m_own & m_sel & pb_oe);
    endfunction

    function automatic logic [N-1:0] exp_out();
        return (m_own & m_dat) | (~m_own & ~m_sel & pa_out) | (~m_own & m_sel & pb_out);
    endfunction

    task automatic check_pads(input string req);
        chk({req, " pad_oe"},  pad_oe,  exp_oe());
        chk({req, " pad_out"}, pad_out, exp_out());
    endtask

    task automatic t_reset();
        logic [N-1:0] v;
        bus_read(4'd2, v);  chk("R1 own reset", v, 32'hFFFF_FF00);
        bus_read(4'd5, v);  chk("R1 sel reset", v, '0);
        bus_read(4'd8, v);  chk("R1 oe reset", v, '0);
        bus_read(4'd11, v); chk("R1 dat reset", v, '0);
        bus_read(4'd14, v); chk("R1 pu reset", v, '0);
        chk("R1 pullups on", pad_pullup_en, '1);
        chk("R6 reset pins follow A oe", pad_oe, pa_oe & 32'h0000_00FF);
    endtask

    task automatic t_setclr();
        logic [N-1:0] v;
        bus_write(4'd9, 32'h0000_F0F0);
        bus_read(4'd11, v); chk("R2 set", v, 32'h0000_F0F0);
        bus_write(4'd9, 32'h0000_0F00);
        bus_read(4'd11, v); chk("R2 set keeps zeros", v, 32'h0000_FFF0);
        bus_write(4'd10, 32'h0000_00F0);
        bus_read(4'd11, v); chk("R2 clear", v, 32'h0000_FF00);
        bus_write(4'd10, 32'h0);
        bus_read(4'd11, v); chk("R2 zero clear no effect", v, 32'h0000_FF00);
        bus_read(4'd9, v);  chk("R9 set addr reads 0", v, '0);
    endtask

    task automatic t_ctrl_drive();
        bus_write(4'd6, 32'hFFFF_0000);
        check_pads("R5 controller drive");
        bus_write(4'd7, 32'h00FF_0000);
        check_pads("R5 oe clear");
    endtask

    task automatic t_periph_sel();
        bus_write(4'd1, 32'h0000_FF00);
        check_pads("R6 sel A");
        bus_write(4'd3, 32'h0000_0F0F);
        check_pads("R6 sel B");
        pad_in = 32'h1234_5678;
        #1;
        chk("R8 pa_in", pa_in, 32'h1234_5678);
        chk("R8 pb_in", pb_in, 32'h1234_5678);
    endtask

    task automatic t_preset();
        bus_write(4'd4, 32'h0000_FF00);
        bus_write(4'd10, 32'h0000_FF00);
        bus_write(4'd9, 32'h0000_5500);
        bus_write(4'd6, 32'h0000_FF00);
        check_pads("R7 still peripheral");
        bus_write(4'd0, 32'h0000_FF00);
        chk("R7 preset oe", pad_oe & 32'h0000_FF00, 32'h0000_FF00);
        chk("R7 preset out", pad_out & 32'h0000_FF00, 32'h0000_5500);
    endtask

    task automatic t_fixed();
        logic [N-1:0] v;
        bus_write(4'd1, 32'hF000_0000);
        bus_read(4'd2, v); chk("R3 locked pins", v & 32'hF000_0000, 32'hF000_0000);
        check_pads("R3 locked pads");
    endtask

    task automatic t_pullup();
        logic [N-1:0] v;
        bus_write(4'd12, 32'h8000_0101);
        chk("R4 pull-up off", pad_pullup_en, 32'h7FFF_FEFE);
        bus_read(4'd14, v); chk("R4 pu status", v, 32'h8000_0101);
        bus_write(4'd13, 32'h0000_0001);
        chk("R4 pull-up on again", pad_pullup_en, 32'h7FFF_FEFF);
    endtask

    task automatic t_rw_collide();
        logic [N-1:0] v, old;
        old = m_dat;
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 4'd9; wr_data = 32'h0000_0001;
        rd_en = 1'b1; rd_addr = 4'd11;
        @(posedge clk);
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0; wr_data = '0;
        m_dat = m_dat | 32'h1;
        chk("R9 same-cycle read old", rd_data, old);
        repeat (3) @(negedge clk);
        chk("R9 hold", rd_data, old);
        bus_read(4'd11, v); chk("R9 next read new", v, m_dat);
        bus_read(4'd15, v); chk("R9 unused addr", v, '0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst_n = 1'b0; wr_en = 1'b0; rd_en = 1'b0;
        wr_addr = '0; rd_addr = '0; wr_data = '0;
        pad_in = 32'hA5A5_0F0F;
        pa_oe  = 32'h0000_F0A5; pa_out = 32'h0000_333C;
        pb_oe  = 32'h0000_0F5A; pb_out = 32'h0000_CCC3;
        m_own = ORST | ~HASP; m_sel = '0; m_oe = '0; m_dat = '0; m_pu = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_setclr();
        t_ctrl_drive();
        t_periph_sel();
        t_preset();
        t_fixed();
        t_pullup();
        t_rw_collide();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule